// File: doc/BRIEF.md
# Carry-Strobe Frequency Divider

This block divides its clock by a fixed whole number, 2229 by default. From a 98.304 MHz source that gives a rate close to 44.1 kHz, within about 52 ppm. It does not compare the count against a limit. Instead, a 12-bit up-counter carries into a 13th flip-flop. While that carry flip-flop is set, the next clock synchronously loads a preset into the counter and clears the carry flip-flop. The preset is chosen so that one full cycle, including the single cycle spent with the carry set, lasts exactly the configured number of clocks.

The block has two outputs:
- **Strobe**: the carry flip-flop itself. It is high for one clock per period and is meant to be used as a clock enable inside the chip.
- **Level**: the counter's top data bit. It has the same period and a long high phase, which suits clocking an external converter.

Everything is clocked on one edge and reset synchronously. No stage of the counting chain ripples.

Top module: `carry_strobe_divider`

## Requirements
- R1: While `rst` is sampled high at a rising edge, the counter is loaded with the preset 2^DATA_W + 1 - PERIOD (1868 for the defaults), with the carry bit cleared. The cycle that follows shows `tick_o` = 0, and `level_o` equals bit DATA_W-1 of that preset (0 for the defaults).
- R2: `tick_o` is never high for two consecutive cycles.
- R3: Once running, consecutive rising edges of `tick_o` are exactly PERIOD clocks apart.
- R4: After the reset is released, the first `tick_o` appears on the PERIOD-1'th rising edge following release.
- R5: `level_o` rises once per PERIOD clocks. For the defaults it stays high for 2048 cycles of each period.
- R6: `level_o` is low in every cycle where `tick_o` is high, and it was high in the cycle just before.
- R7: A reset applied at any point, including the cycle in which `tick_o` is high, drops `tick_o` on the next edge and restarts the sequence of R4.
- R8: The only legal parameter range is 2 ≤ PERIOD ≤ 2^DATA_W. Within it, the counter runs from the preset up to 2^DATA_W, visiting PERIOD states in all.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_o | output | 1 | One-clock strobe per period (the carry bit) |
| level_o | output | 1 | Top data bit of the counter: long-high signal at the output rate |

## Verification
The assertions assume that `clk` is free-running and that `rst` only changes away from the rising edge. They place no limit on when or for how long reset is applied: a reset may land on the carry cycle, last one cycle, or last many.

The stimulus changes `rst` only on falling edges. Random run lengths, between one clock and three periods, are mixed with random reset lengths. Directed cases cover a reset landing on the carry cycle and a single-cycle reset.

// File: rtl/csd_pkg.sv
package csd_pkg;

  // Load value so that preset .. 2^width (carry state) spans exactly 'period' states.
  function automatic int unsigned csd_preset(input int unsigned period,
                                             input int unsigned width);
    return (32'd1 << width) + 32'd1 - period;
  endfunction

  // Number of states in one cycle, restated from the preset.
  function automatic int unsigned csd_span(input int unsigned preset,
                                           input int unsigned width);
    return (32'd1 << width) - preset + 32'd1;
  endfunction

endpackage

// File: rtl/csd_counter.sv
module csd_counter #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned PERIOD = 2229
) (
  input  logic              clk,
  input  logic              rst,
  output logic              carry_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned       PRESET_I = csd_pkg::csd_preset(PERIOD, DATA_W);
  localparam logic [DATA_W-1:0] PRESET   = DATA_W'(PRESET_I);
  localparam logic [DATA_W:0]   ONE      = (DATA_W+1)'(1);

  logic [DATA_W:0] cnt_q;
  logic            reload_w;
  logic            rst_q;

  // Synchronous preset load on reset or while the carry bit is set.
  assign reload_w = rst | cnt_q[DATA_W];

  always_ff @(posedge clk) begin
    if (reload_w) cnt_q <= {1'b0, PRESET};
    else          cnt_q <= cnt_q + ONE;
  end

  assign carry_o = cnt_q[DATA_W];
  assign data_o  = cnt_q[DATA_W-1:0];

  always_ff @(posedge clk) rst_q <= rst;

  always_ff @(posedge clk) begin
    if (rst_q) begin
      AST_RESET_LOADS_PRESET: assert (!carry_o && data_o == PRESET); // R1
    end
  end

  AST_RELOAD_AFTER_CARRY: assert property (@(posedge clk) disable iff (rst)
    carry_o |=> (!carry_o && data_o == PRESET)); // R8

  AST_CARRY_FROM_FULL: assert property (@(posedge clk) disable iff (rst)
    $rose(carry_o) |-> ($past(data_o) == {DATA_W{1'b1}})); // R8

  initial begin
    AST_PARAM_RANGE: assert (PERIOD >= 2 && PERIOD <= (32'd1 << DATA_W)
      && csd_pkg::csd_span(PRESET_I, DATA_W) == PERIOD); // R8
  end

endmodule

// File: rtl/csd_taps.sv
module csd_taps #(
  parameter int unsigned DATA_W = 12
) (
  input  logic              carry_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              tick_o,
  output logic              level_o
);
  // Strobe is the carry flop itself; level is the top data bit.
  assign tick_o  = carry_i;
  assign level_o = data_i[DATA_W-1];
endmodule

// File: rtl/carry_strobe_divider.sv
module carry_strobe_divider #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned PERIOD = 2229
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o,
  output logic level_o
);
  localparam logic [DATA_W:0] LAST_IDX = (DATA_W+1)'(PERIOD - 1);
  localparam logic [DATA_W:0] ONE      = (DATA_W+1)'(1);

  logic              carry_w;
  logic [DATA_W-1:0] data_w;

  csd_counter #(.DATA_W(DATA_W), .PERIOD(PERIOD)) u_counter (
    .clk     (clk),
    .rst     (rst),
    .carry_o (carry_w),
    .data_o  (data_w)
  );

  csd_taps #(.DATA_W(DATA_W)) u_taps (
    .carry_i (carry_w),
    .data_i  (data_w),
    .tick_o  (tick_o),
    .level_o (level_o)
  );

  // Edges since reset or last strobe, for the period assertions only.
  logic [DATA_W:0] gap_q;
  always_ff @(posedge clk) begin
    if (rst || tick_o) gap_q <= '0;
    else               gap_q <= gap_q + ONE;
  end

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o); // R2

  AST_TICK_AT_PERIOD: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> (gap_q == LAST_IDX)); // R3

  AST_NO_EARLY_LATE_TICK: assert property (@(posedge clk) disable iff (rst)
    (gap_q == LAST_IDX) |-> tick_o); // R4

  AST_LEVEL_FALLS_AT_TICK: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> (!level_o && $past(level_o))); // R6

endmodule

// File: tb/test_carry_strobe_divider.sv
module test_carry_strobe_divider;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 12;
  localparam int P  = 2229;
  localparam int PRE = (1 << W) + 1 - P;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_o, level_o;

  int errors = 0;
  int checks = 0;
  int k = 0;          // edges since reset release
  int cyc = 0;
  bit started = 0;

  // trackers
  bit prev_tick = 0, prev_level = 0;
  bit have_tick = 0, have_lvl = 0, first_pending = 0;
  int last_tick_cyc = 0, last_lvl_cyc = 0, tick_rise_cyc = 0, lvl_rise_cyc = 0;
  bit lvl_run_valid = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  carry_strobe_divider #(.DATA_W(W), .PERIOD(P)) i_carry_strobe_divider (
    .clk(clk), .rst(rst), .tick_o(tick_o), .level_o(level_o)
  );

  function automatic bit exp_tick(input int idx);
    return idx == P - 1;
  endfunction

  function automatic bit exp_level(input int idx);
    int v;
    if (idx == P - 1) return 1'b0;
    v = PRE + idx;
    return v[W-1];
  endfunction

  function automatic int exp_high_len();
    int n = 0;
    for (int i = 0; i < P - 1; i++) if (exp_level(i)) n++;
    return n;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  task automatic tick();
    bit r;
    int idx;
    r = rst;
    @(posedge clk);
    cyc++;
    if (r) k = 0; else k++;
    @(negedge clk);
    started = 1;
    idx = k % P;
    if (r) begin
      chk(tick_o == 1'b0, "R1 tick in reset", int'(tick_o), 0);
      chk(level_o == exp_level(0), "R1 level in reset", int'(level_o), int'(exp_level(0)));
      have_tick = 0; have_lvl = 0; lvl_run_valid = 0; first_pending = 1;
    end else begin
      chk(tick_o == exp_tick(idx), "R3 tick model", int'(tick_o), int'(exp_tick(idx)));
      chk(level_o == exp_level(idx), "R5 level model", int'(level_o), int'(exp_level(idx)));
      if (tick_o) chk(!level_o && prev_level, "R6 level at tick", int'(level_o), 0);
      if (tick_o && !prev_tick) begin
        if (have_tick) chk(cyc - last_tick_cyc == P, "R3 tick spacing", cyc - last_tick_cyc, P);
        if (first_pending) chk(k == P - 1, "R4 first tick", k, P - 1);
        first_pending = 0;
        have_tick = 1; last_tick_cyc = cyc; tick_rise_cyc = cyc;
      end
      if (!tick_o && prev_tick && have_tick)
        chk(cyc - tick_rise_cyc == 1, "R2 tick width", cyc - tick_rise_cyc, 1);
      if (level_o && !prev_level) begin
        if (have_lvl) chk(cyc - last_lvl_cyc == P, "R5 level spacing", cyc - last_lvl_cyc, P);
        have_lvl = 1; last_lvl_cyc = cyc; lvl_rise_cyc = cyc; lvl_run_valid = 1;
      end
      if (!level_o && prev_level && lvl_run_valid)
        chk(cyc - lvl_rise_cyc == exp_high_len(), "R5 level high length",
            cyc - lvl_rise_cyc, exp_high_len());
    end
    prev_tick = tick_o;
    prev_level = level_o;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2229));
    rst = 1'b1;
    run(3);                         // R1 reset state
    @(negedge clk); rst = 1'b0;
    run(3 * P + 5);                 // R2 R3 R4 R5 R6 free running

    // R7: reset landing exactly on the carry cycle
    while (!tick_o) tick();
    rst = 1'b1;
    tick();
    chk(tick_o == 1'b0, "R7 reset on carry", int'(tick_o), 0);
    rst = 1'b0;
    run(2 * P + 3);

    // R7: single-cycle reset mid count
    run(777);
    rst = 1'b1; tick(); rst = 1'b0;
    run(P + 10);

    // R7: random run and reset lengths
    for (int j = 0; j < 6; j++) begin
      run($urandom_range(1, 3 * P));
      rst = 1'b1;
      run($urandom_range(1, 4));
      rst = 1'b0;
    end
    run(P + 2);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule